// File: doc/BRIEF.md
# Reverse Polish Expression Evaluator

This block evaluates integer arithmetic expressions that arrive as a stream of tokens in postfix order. The expression carries no brackets; token order alone fixes the order of evaluation, as in `a b + c d - * e f /`. An internal register stack holds intermediate values. Operand tokens are pushed. An operator pops one or two entries, depending on its arity, and pushes its result. An end token pops the last remaining entry onto the result port.

Tokens use a valid/ready handshake. Every token is taken in one cycle, except for a divide. A divide runs on an iterative divider and holds ready low until its quotient has been written back. A malformed expression raises a one-cycle error pulse and is dropped. Malformed means any of: stack underflow, stack overflow, division by zero, an unknown operator code, or an end token when the stack does not hold exactly one entry. After a result or an error the stack is empty and ready for the next expression.

Top module: `rpn_eval`

## Requirements
- R1: Token kind field `tok_kind_i`: 0 = operand, 1 = binary operator, 2 = unary operator, 3 = end. An accepted operand pushes `tok_data_i`. An end token with exactly one entry on the stack drives that entry on `res_data_o` with `res_valid_o` high for one cycle, in the cycle after acceptance.
- R2: Binary codes on `tok_op_i`: 0 = add, 1 = subtract, 2 = multiply. Each result is the low 16 bits of the exact two's complement result.
- R3: For a binary operator, the top entry is the right-hand operand and the entry below it is the left-hand operand.
- R4: Unary codes: 0 = negate, 1 = absolute value. Both replace the top entry and wrap to 16 bits, so the absolute value of -32768 is -32768.
- R5: Binary code 3 divides, truncating toward zero, with a wrapped quotient. While the divide runs, `tok_ready_o` is low in the cycle after the divide token is accepted.
- R6: A divide whose right-hand operand is zero raises `err_o`.
- R7: A binary operator with fewer than two entries, or a unary operator on an empty stack, raises `err_o`.
- R8: An operand arriving while the stack holds DEPTH entries raises `err_o`.
- R9: An end token with a stack depth other than one raises `err_o` and gives no result.
- R10: `err_o` and `res_valid_o` are never high together. After either one the stack is empty, so the next expression does not depend on the last.
- R11: Binary codes 4 to 7 and unary codes 2 to 7 raise `err_o`.
- R12: After reset `tok_ready_o` is high and `res_valid_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_valid_i | input | 1 | Token present |
| tok_ready_o | output | 1 | Token can be taken this cycle |
| tok_kind_i | input | 2 | Token kind |
| tok_op_i | input | 3 | Operator code |
| tok_data_i | input | DATA_W | Signed operand value |
| res_valid_o | output | 1 | Result pulse |
| res_data_o | output | DATA_W | Result value |
| err_o | output | 1 | Error pulse; expression dropped |

## Verification
The divider writing its quotient back to the stack and the next token arriving can fall in the same cycle. Both would update the stack at one edge. To provoke this, the bench presents the next token as soon as a divide token is accepted. It checks that ready is low in the following cycle. The value of every later result then shows whether the stack saw the write-back and the new token in the right order.

// File: rtl/rpn_pkg.sv
package rpn_pkg;
  typedef enum logic [1:0] {
    TK_OPND = 2'd0,
    TK_BIN  = 2'd1,
    TK_UN   = 2'd2,
    TK_END  = 2'd3
  } tok_kind_e;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_MUL = 3'd2;
  localparam logic [2:0] OP_DIV = 3'd3;
  localparam logic [2:0] OP_NEG = 3'd0;
  localparam logic [2:0] OP_ABS = 3'd1;

  typedef enum logic [2:0] {
    SC_NONE,
    SC_PUSH,
    SC_REPL,
    SC_POP2,
    SC_CLEAR
  } stk_cmd_e;
endpackage

// File: rtl/rpn_stack.sv
module rpn_stack
  import rpn_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_cmd_e         cmd_i,
  input  logic [W-1:0]     wval_i,
  output logic [W-1:0]     top_o,
  output logic [W-1:0]     next_o,
  output logic [PTR_W-1:0] depth_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] depth_q;
  logic [PTR_W-1:0] d_m1, d_m2;

  assign d_m1    = depth_q - PTR_W'(1);
  assign d_m2    = depth_q - PTR_W'(2);
  assign top_o   = (depth_q != '0) ? mem_q[d_m1[IDX_W-1:0]] : '0;
  assign next_o  = (depth_q > PTR_W'(1)) ? mem_q[d_m2[IDX_W-1:0]] : '0;
  assign depth_o = depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      unique case (cmd_i)
        SC_PUSH: begin
          mem_q[depth_q[IDX_W-1:0]] <= wval_i;
          depth_q <= depth_q + PTR_W'(1);
        end
        SC_REPL: mem_q[d_m1[IDX_W-1:0]] <= wval_i;
        SC_POP2: begin
          mem_q[d_m2[IDX_W-1:0]] <= wval_i;
          depth_q <= d_m1;
        end
        SC_CLEAR: depth_q <= '0;
        default: ;
      endcase
    end
  end

  p_depth_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q <= PTR_W'(DEPTH));
  p_push_room_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == SC_PUSH |-> depth_q < PTR_W'(DEPTH));
  p_pop_two_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == SC_POP2 |-> depth_q >= PTR_W'(2));
  p_repl_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == SC_REPL |-> depth_q >= PTR_W'(1));
endmodule

// File: rtl/rpn_alu.sv
module rpn_alu
  import rpn_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         unary_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] lhs_i,
  input  logic [W-1:0] rhs_i,
  output logic [W-1:0] res_o,
  output logic         ok_o,
  output logic         is_div_o
);
  always_comb begin
    res_o    = '0;
    ok_o     = 1'b1;
    is_div_o = 1'b0;
    if (unary_i) begin
      unique case (op_i)
        OP_NEG:  res_o = -rhs_i;
        OP_ABS:  res_o = rhs_i[W-1] ? -rhs_i : rhs_i;
        default: ok_o = 1'b0;
      endcase
    end else begin
      unique case (op_i)
        OP_ADD:  res_o = lhs_i + rhs_i;
        OP_SUB:  res_o = lhs_i - rhs_i;
        OP_MUL:  res_o = lhs_i * rhs_i;
        OP_DIV:  is_div_o = 1'b1;
        default: ok_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rpn_div.sv
module rpn_div #(
  parameter int W = 16,
  localparam int CNT_W = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  logic [W-1:0]     rem_q, quo_q, dvs_q;
  logic             neg_q, busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       shl;
  logic [W+1:0]     diff;
  logic [W-1:0]     a_mag, b_mag;

  assign a_mag  = dividend_i[W-1] ? -dividend_i : dividend_i;
  assign b_mag  = divisor_i[W-1] ? -divisor_i : divisor_i;
  assign shl    = {rem_q, quo_q[W-1]};
  assign diff   = {1'b0, shl} - {2'b0, dvs_q};
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = neg_q ? -quo_q : quo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      neg_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        quo_q  <= a_mag;
        dvs_q  <= b_mag;
        neg_q  <= dividend_i[W-1] ^ divisor_i[W-1];
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (!diff[W+1]) begin
          rem_q <= diff[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= shl[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_start_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q && !done_q);
  p_done_after_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(busy_q));
endmodule

// File: rtl/rpn_eval.sv
module rpn_eval
  import rpn_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tok_valid_i,
  output logic              tok_ready_o,
  input  logic [1:0]        tok_kind_i,
  input  logic [2:0]        tok_op_i,
  input  logic [DATA_W-1:0] tok_data_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              err_o
);
  tok_kind_e         kind;
  stk_cmd_e          cmd;
  logic [DATA_W-1:0] wval, top, nxt, alu_res, div_q;
  logic [PTR_W-1:0]  depth;
  logic              accept, alu_ok, is_div;
  logic              div_start, div_busy, div_done;
  logic              err_d, res_d;
  logic              res_valid_q, err_q;
  logic [DATA_W-1:0] res_data_q;

  assign kind        = tok_kind_e'(tok_kind_i);
  assign tok_ready_o = !(div_busy || div_done);
  assign accept      = tok_valid_i && tok_ready_o;

  rpn_stack #(.W(DATA_W), .DEPTH(DEPTH)) i_stack (
    .clk_i, .rst_ni,
    .cmd_i(cmd), .wval_i(wval),
    .top_o(top), .next_o(nxt), .depth_o(depth)
  );

  rpn_alu #(.W(DATA_W)) i_alu (
    .unary_i(kind == TK_UN), .op_i(tok_op_i),
    .lhs_i(nxt), .rhs_i(top),
    .res_o(alu_res), .ok_o(alu_ok), .is_div_o(is_div)
  );

  rpn_div #(.W(DATA_W)) i_div (
    .clk_i, .rst_ni,
    .start_i(div_start), .dividend_i(nxt), .divisor_i(top),
    .busy_o(div_busy), .done_o(div_done), .quot_o(div_q)
  );

  always_comb begin
    cmd       = SC_NONE;
    wval      = '0;
    div_start = 1'b0;
    err_d     = 1'b0;
    res_d     = 1'b0;
    if (div_done) begin
      cmd  = SC_POP2;
      wval = div_q;
    end else if (accept) begin
      unique case (kind)
        TK_OPND:
          if (depth == PTR_W'(DEPTH)) err_d = 1'b1;
          else begin
            cmd  = SC_PUSH;
            wval = tok_data_i;
          end
        TK_BIN:
          if (depth < PTR_W'(2) || !alu_ok) err_d = 1'b1;
          else if (is_div) begin
            if (top == '0) err_d = 1'b1;
            else div_start = 1'b1;
          end else begin
            cmd  = SC_POP2;
            wval = alu_res;
          end
        TK_UN:
          if (depth == '0 || !alu_ok) err_d = 1'b1;
          else begin
            cmd  = SC_REPL;
            wval = alu_res;
          end
        TK_END:
          if (depth != PTR_W'(1)) err_d = 1'b1;
          else begin
            res_d = 1'b1;
            cmd   = SC_CLEAR;
          end
        default: ;
      endcase
    end
    if (err_d) cmd = SC_CLEAR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      err_q       <= 1'b0;
      res_data_q  <= '0;
    end else begin
      res_valid_q <= res_d;
      err_q       <= err_d;
      if (res_d) res_data_q <= top;
    end
  end

  assign res_valid_o = res_valid_q;
  assign err_o       = err_q;
  assign res_data_o  = res_data_q;

  p_res_err_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_o && err_o));
  p_clear_after_out_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o || err_o) |-> depth == '0);
  p_div_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_start |-> top != '0);
  p_hold_during_div_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_start |=> !tok_ready_o);
  p_res_from_end_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(tok_valid_i) && $past(tok_kind_i) == 2'd3);
endmodule

// File: tb/test_rpn_eval.sv
module test_rpn_eval;
  localparam int W     = 16;
  localparam int DEPTH = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tok_valid = 1'b0;
  logic         tok_ready;
  logic [1:0]   tok_kind = '0;
  logic [2:0]   tok_op = '0;
  logic [W-1:0] tok_data = '0;
  logic         res_valid, err;
  logic [W-1:0] res_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  bit           q_err [$];
  logic [W-1:0] q_val [$];
  string        q_tag [$];

  always #2.5 clk = ~clk;

  rpn_eval #(.DATA_W(W), .DEPTH(DEPTH)) i_rpn_eval (
    .clk_i(clk), .rst_ni(rst_ni),
    .tok_valid_i(tok_valid), .tok_ready_o(tok_ready),
    .tok_kind_i(tok_kind), .tok_op_i(tok_op), .tok_data_i(tok_data),
    .res_valid_o(res_valid), .res_data_o(res_data), .err_o(err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tok(input logic [1:0] k, input logic [2:0] o, input int d);
    tok_kind  = k;
    tok_op    = o;
    tok_data  = W'(d);
    tok_valid = 1'b1;
    while (!tok_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic opnd(input int d);       tok(2'd0, 3'd0, d); endtask
  task automatic bin(input logic [2:0] o); tok(2'd1, o, 0);   endtask
  task automatic un(input logic [2:0] o);  tok(2'd2, o, 0);   endtask
  task automatic fin();                    tok(2'd3, 3'd0, 0); endtask

  task automatic exp_val(input int v, input string tag);
    q_err.push_back(1'b0);
    q_val.push_back(W'(v));
    q_tag.push_back(tag);
  endtask

  task automatic exp_err(input string tag);
    q_err.push_back(1'b1);
    q_val.push_back('0);
    q_tag.push_back(tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && (res_valid || err)) begin
      if (q_err.size() == 0) begin
        check(1'b0, "R10 unexpected output", int'(res_data), 0);
      end else begin
        automatic bit           e_err = q_err.pop_front();
        automatic logic [W-1:0] e_val = q_val.pop_front();
        automatic string        e_tag = q_tag.pop_front();
        if (e_err)
          check(err && !res_valid, e_tag, int'(res_valid), 0);
        else
          check(res_valid && !err && res_data == e_val, e_tag,
                int'($signed(res_data)), int'($signed(e_val)));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(tok_ready && !res_valid && !err, "R12 reset state",
          int'({tok_ready, res_valid, err}), 4);

    exp_val(42, "R1 single operand");
    opnd(42); fin();

    exp_val(5 - 9, "R3 operand order sub");
    opnd(5); opnd(9); bin(3'd1); fin();

    // (3+4)*(10-2)/5; next token held against divide write-back
    exp_val(((3 + 4) * (10 - 2)) / 5, "R2 mixed expression");
    opnd(3); opnd(4); bin(3'd0); opnd(10); opnd(2); bin(3'd1); bin(3'd2);
    opnd(5); bin(3'd3);
    check(!tok_ready, "R5 ready low during divide", int'(tok_ready), 0);
    fin();

    exp_val(300 * 300, "R2 multiply wrap");
    opnd(300); opnd(300); bin(3'd2); fin();
    exp_val(32767 + 1, "R2 add wrap");
    opnd(32767); opnd(1); bin(3'd0); fin();

    exp_val(-7, "R4 negate");
    opnd(7); un(3'd0); fin();
    exp_val(9, "R4 abs");
    opnd(-9); un(3'd1); fin();
    exp_val(-32768, "R4 abs wrap");
    opnd(-32768); un(3'd1); fin();

    exp_val(-3, "R5 neg dividend");
    opnd(-7); opnd(2); bin(3'd3); fin();
    exp_val(-3, "R5 neg divisor");
    opnd(7); opnd(-2); bin(3'd3); fin();
    exp_val(14, "R3 divide order");
    opnd(100); opnd(7); bin(3'd3); fin();
    exp_val(-32768, "R5 divide wrap");
    opnd(-32768); opnd(-1); bin(3'd3); fin();
    exp_val(-8 / 2, "R5 back to back divides");
    opnd(-8); opnd(2); opnd(1); bin(3'd3); bin(3'd3); fin();

    exp_err("R6 divide by zero");
    opnd(5); opnd(0); bin(3'd3);
    exp_val(3, "R10 clean after error");
    opnd(1); opnd(2); bin(3'd0); fin();

    exp_err("R7 binary underflow");
    opnd(5); bin(3'd0);
    exp_err("R7 unary on empty");
    un(3'd0);

    exp_err("R8 overflow");
    for (int i = 0; i < DEPTH + 1; i++) opnd(i);
    exp_err("R9 end on empty");
    fin();

    exp_err("R9 end with two entries");
    opnd(1); opnd(2); fin();

    exp_err("R11 bad binary code");
    opnd(1); opnd(2); bin(3'd5);
    exp_err("R11 bad unary code");
    opnd(1); un(3'd3);

    exp_val(DEPTH * 2, "R8 full stack legal");
    for (int i = 0; i < DEPTH; i++) opnd(2);
    for (int i = 0; i < DEPTH - 1; i++) bin(3'd0);
    fin();

    exp_val(42, "R10 next expression independent");
    opnd(6); opnd(7); bin(3'd2); fin();

    repeat (4) @(negedge clk);
    check(q_err.size() == 0, "R10 all outputs seen", q_err.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule